// File: doc/BRIEF.md
# Function Configuration Register File with Base-Address Sizing

This block holds the 256-byte configuration space of a single bus function. It is the storage behind a configuration-access port decoder. The decoder presents one dword-aligned access per cycle: a dword index, four byte enables and write data. The block applies a fixed writability rule to each enabled byte and stores the bytes that are allowed. It then reports any side effects as one-cycle pulses in the cycle after the write.

Six base address registers sit at dwords 4 to 9. Each one is given a kind (unused, I/O or 32-bit memory), a size and a default base when the block is elaborated. A write to one of them is merged byte-wise into the old value. The result is then cut down to the decoded size, and the kind's flag bits are forced. Software can therefore probe a register's size by writing all ones and reading the value back. The register reprogram pulse and the expansion-ROM pulse tell the surrounding logic that it must move its decoders. The command byte drives the I/O-enable and memory-enable outputs directly.

Top module: `cfg_space_bars`

## Requirements
- R1: After reset: dword 0 reads ID_WORD, dword 2 reads CLASS_WORD, and byte 0x0E (bits 23:16 of dword 3) reads HDR_TYPE. Each base register reads (default base AND its address mask) OR its flag bits. All other bytes read 0, and io_en, mem_en, bar_evt, rom_evt and wr_err are 0.
- R2: rd_data shows the dword selected by rd_dw combinationally, with byte offset 4*rd_dw+k in bits 8k+7:8k. Reads change no state.
- R3: The following byte offsets are writable: 0x04, 0x05, 0x0C, 0x0D, 0x0F, 0x10–0x27, 0x30–0x33, 0x3C and 0x40–0xFF. An enabled writable byte is visible on a read in the cycle after the write.
- R4: An enabled byte at any other offset keeps its value, and wr_err is 1 for exactly the cycle after the write. Writable lanes of the same write still take effect.
- R5: io_en equals bit 0 and mem_en equals bit 1 of the byte at offset 0x04. A write to that byte changes them in the next cycle.
- R6: Any write to offset 0x0F stores 0x00.
- R7: An I/O base register of N ports (bits 2*i+1:2*i of BAR_KIND = 1) stores (merged & ~(N-1) & ~3) | 1.
- R8: A 32-bit memory base register of P 4-KiB pages (kind = 2) stores (merged & ~((P<<12)-1)) | 8. This makes bits 3:0 read 0x8.
- R9: An unused base register (kind = 0) always reads 0, and every write to it is discarded.
- R10: In the cycle after a write with any enabled lane in dwords 4–9, bar_evt is 1 for one cycle. bar_evt_idx then equals dword-4, and bar_evt_val equals that register's new stored value.
- R11: A write with any enabled lane in dword 12 (offsets 0x30–0x33) stores those bytes, and rom_evt is 1 for the one cycle after.
- R12: When HDR_TYPE is neither 0x00 nor 0x80, no write changes any byte or raises bar_evt or rom_evt. Every write with a nonzero byte enable pulses wr_err.
- R13: A cycle with wr_en low, or with wr_be equal to 0, changes nothing and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the addressed dword |
| wr_dw | input | 6 | Dword index of the write |
| wr_be | input | 4 | Byte enables of the write, bit k for byte offset 4*wr_dw+k |
| wr_data | input | 32 | Write data, byte k in bits 8k+7:8k |
| rd_dw | input | 6 | Dword index to read |
| rd_data | output | 32 | Dword contents at rd_dw |
| io_en | output | 1 | I/O space enable from the command byte |
| mem_en | output | 1 | Memory space enable from the command byte |
| bar_evt | output | 1 | One-cycle pulse: a base register was written |
| bar_evt_idx | output | 3 | Index 0–5 of that register, valid with bar_evt |
| bar_evt_val | output | 32 | New stored value of that register, valid with bar_evt |
| rom_evt | output | 1 | One-cycle pulse: the expansion-ROM dword was written |
| wr_err | output | 1 | One-cycle pulse: a write hit a read-only byte or the header type is invalid |

## Verification
The bench writes all ones to each kind of base register. A wrong mask shows up as a wrong readback: low address bits are kept, or the I/O bit 0 or the memory nibble 0x8 is lost. It also makes a one-lane write into the middle of a register. A design that replaced the whole dword instead of merging would lose the untouched bytes. Mixed writes combine a writable lane with read-only lanes, for example the command word with the status bytes, the BIST dword and the interrupt-line dword. These catch a design that drops the whole write, stores into read-only bytes, misses the error pulse or lets the BIST byte keep its data. A second instance with an invalid header type gets the same stimulus. Here a design that skipped the header check would change stored bytes or emit reprogram pulses.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

  localparam int NUM_BARS    = 6;
  localparam int NUM_DW      = 64;
  localparam int DW_W        = $clog2(NUM_DW);
  localparam int BAR_IDX_W   = 3;
  localparam int BAR_DW_LO   = 4;
  localparam int ROM_DW      = 12;
  localparam int CMD_DW      = 1;
  localparam int BIST_DW     = 3;
  localparam int BIST_LANE   = 3;
  localparam int LANES       = 4;

  typedef enum logic [1:0] {
    BAR_NONE  = 2'd0,
    BAR_IO    = 2'd1,
    BAR_MEM32 = 2'd2
  } bar_kind_e;

  function automatic logic hdr_valid(input logic [7:0] hdr);
    return (hdr == 8'h00) || (hdr == 8'h80);
  endfunction

  function automatic logic off_writable(input logic [7:0] off);
    logic ok;
    case (off) inside
      8'h04, 8'h05, 8'h0C, 8'h0D, 8'h0F: ok = 1'b1;
      [8'h10:8'h27]:                     ok = 1'b1;
      [8'h30:8'h33]:                     ok = 1'b1;
      8'h3C:                             ok = 1'b1;
      default:                           ok = (off >= 8'h40);
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/cfg_lane_rules.sv
module cfg_lane_rules
  import cfg_space_pkg::*;
(
  input  logic            wr_en,
  input  logic [DW_W-1:0] wr_dw,
  input  logic [LANES-1:0] wr_be,
  input  logic            hdr_ok,
  output logic [LANES-1:0] lane_wr,
  output logic            ro_hit
);

  logic [LANES-1:0] lane_ro;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] off;
    logic       ok;
    always_comb begin
      off        = {wr_dw, 2'(l)};
      ok         = off_writable(off);
      lane_wr[l] = wr_en && wr_be[l] && hdr_ok && ok;
      lane_ro[l] = wr_en && wr_be[l] && !(hdr_ok && ok);
    end
  end

  assign ro_hit = |lane_ro;

endmodule

// File: rtl/cfg_bar_unit.sv
module cfg_bar_unit
  import cfg_space_pkg::*;
#(
  parameter bar_kind_e   KIND = BAR_NONE,
  parameter logic [31:0] SIZE = 32'd0,
  parameter logic [31:0] BASE = 32'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic [LANES-1:0] lane_wr,
  input  logic [31:0]      wr_data,
  output logic [31:0]      bar_q
);

  localparam logic [31:0] ADDR_MASK =
    (KIND == BAR_IO)    ? (~(SIZE - 32'd1) & ~32'h3) :
    (KIND == BAR_MEM32) ? ~((SIZE << 12) - 32'd1)    : 32'h0;
  localparam logic [31:0] FLAGS =
    (KIND == BAR_IO)    ? 32'h1 :
    (KIND == BAR_MEM32) ? 32'h8 : 32'h0;
  localparam logic [31:0] RST_VAL = (BASE & ADDR_MASK) | FLAGS;

  logic        bar_en;
  logic [31:0] merged;
  logic [31:0] bar_d;

  always_comb begin
    bar_en = sel && (|lane_wr);
    merged = bar_q;
    for (int l = 0; l < LANES; l++) begin
      if (lane_wr[l]) merged[8*l +: 8] = wr_data[8*l +: 8];
    end
    bar_d = (merged & ADDR_MASK) | FLAGS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bar_q <= RST_VAL;
    else if (bar_en) bar_q <= bar_d;
  end

endmodule

// File: rtl/cfg_space_bars.sv
module cfg_space_bars
  import cfg_space_pkg::*;
#(
  parameter logic [31:0]             ID_WORD    = 32'h7A31_10EE,
  parameter logic [31:0]             CLASS_WORD = 32'h0C03_0002,
  parameter logic [7:0]              HDR_TYPE   = 8'h00,
  parameter logic [2*NUM_BARS-1:0]   BAR_KIND   = 12'h009,
  parameter logic [32*NUM_BARS-1:0]  BAR_SIZE   = {128'h0, 32'd4, 32'd32},
  parameter logic [32*NUM_BARS-1:0]  BAR_BASE   = {128'h0, 32'hFEB0_0000, 32'h0000_C000}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [5:0]           wr_dw,
  input  logic [3:0]           wr_be,
  input  logic [31:0]          wr_data,
  input  logic [5:0]           rd_dw,
  output logic [31:0]          rd_data,
  output logic                 io_en,
  output logic                 mem_en,
  output logic                 bar_evt,
  output logic [2:0]           bar_evt_idx,
  output logic [31:0]          bar_evt_val,
  output logic                 rom_evt,
  output logic                 wr_err
);

  localparam logic HDR_OK = hdr_valid(HDR_TYPE);

  // reset: asynchronous assertion, two-stage synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // per-lane write qualification
  logic [LANES-1:0] lane_wr;
  logic             ro_hit;

  cfg_lane_rules u_rules (
    .wr_en   (wr_en),
    .wr_dw   (wr_dw),
    .wr_be   (wr_be),
    .hdr_ok  (HDR_OK),
    .lane_wr (lane_wr),
    .ro_hit  (ro_hit)
  );

  // base address registers
  logic [31:0] bar_val [NUM_BARS];

  for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
    logic bar_sel;
    assign bar_sel = (wr_dw == DW_W'(BAR_DW_LO + b));
    cfg_bar_unit #(
      .KIND (bar_kind_e'(BAR_KIND[2*b +: 2])),
      .SIZE (BAR_SIZE[32*b +: 32]),
      .BASE (BAR_BASE[32*b +: 32])
    ) u_bar (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .sel     (bar_sel),
      .lane_wr (lane_wr),
      .wr_data (wr_data),
      .bar_q   (bar_val[b])
    );
  end

  // plain dword storage
  logic [31:0] cfg_q [NUM_DW];

  for (genvar d = 0; d < NUM_DW; d++) begin : g_dw
    if (d >= BAR_DW_LO && d < BAR_DW_LO + NUM_BARS) begin : g_alias
      assign cfg_q[d] = bar_val[d - BAR_DW_LO];
    end else begin : g_reg
      localparam logic [31:0] RST_WORD =
        (d == 0) ? ID_WORD :
        (d == 2) ? CLASS_WORD :
        (d == 3) ? {8'h00, HDR_TYPE, 16'h0000} : 32'h0;
      logic        dw_en;
      logic [31:0] dw_d;
      logic [31:0] dw_q;

      always_comb begin
        dw_en = (wr_dw == DW_W'(d)) && (|lane_wr);
        dw_d  = dw_q;
        for (int l = 0; l < LANES; l++) begin
          if (lane_wr[l]) begin
            if (d == BIST_DW && l == BIST_LANE) dw_d[8*l +: 8] = 8'h00;
            else                                dw_d[8*l +: 8] = wr_data[8*l +: 8];
          end
        end
      end

      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) dw_q <= RST_WORD;
        else if (dw_en) dw_q <= dw_d;
      end

      assign cfg_q[d] = dw_q;
    end
  end

  assign rd_data = cfg_q[rd_dw];
  assign io_en   = cfg_q[CMD_DW][0];
  assign mem_en  = cfg_q[CMD_DW][1];

  // side-effect pulses
  logic       bar_hit, rom_hit;
  logic       bar_evt_d, rom_evt_d, err_d;
  logic [2:0] idx_d;
  logic       bar_evt_q, rom_evt_q, err_q;
  logic [2:0] idx_q;

  always_comb begin
    bar_hit   = (wr_dw >= DW_W'(BAR_DW_LO)) && (wr_dw < DW_W'(BAR_DW_LO + NUM_BARS));
    rom_hit   = (wr_dw == DW_W'(ROM_DW));
    bar_evt_d = bar_hit && (|lane_wr);
    rom_evt_d = rom_hit && (|lane_wr);
    err_d     = ro_hit;
    idx_d     = bar_evt_d ? 3'(wr_dw - DW_W'(BAR_DW_LO)) : idx_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      bar_evt_q <= 1'b0;
      rom_evt_q <= 1'b0;
      err_q     <= 1'b0;
      idx_q     <= 3'd0;
    end else begin
      bar_evt_q <= bar_evt_d;
      rom_evt_q <= rom_evt_d;
      err_q     <= err_d;
      idx_q     <= idx_d;
    end
  end

  always_comb begin
    bar_evt_val = 32'h0;
    for (int b = 0; b < NUM_BARS; b++) begin
      if (idx_q == 3'(b)) bar_evt_val = bar_val[b];
    end
  end

  assign bar_evt     = bar_evt_q;
  assign rom_evt     = rom_evt_q;
  assign wr_err      = err_q;
  assign bar_evt_idx = idx_q;

endmodule

// File: rtl/cfg_space_bars_chk.sv
module cfg_space_bars_chk
  import cfg_space_pkg::*;
#(
  parameter logic [2*NUM_BARS-1:0] BAR_KIND = 12'h009,
  parameter logic [7:0]            HDR_TYPE = 8'h00
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [5:0]  wr_dw,
  input logic [3:0]  wr_be,
  input logic [31:0] wr_data,
  input logic        io_en,
  input logic        mem_en,
  input logic        bar_evt,
  input logic [2:0]  bar_evt_idx,
  input logic [31:0] bar_evt_val,
  input logic        rom_evt,
  input logic        wr_err
);

  localparam logic HDR_OK = hdr_valid(HDR_TYPE);

  logic [1:0] evt_kind;
  always_comb begin
    evt_kind = 2'd0;
    for (int b = 0; b < NUM_BARS; b++) begin
      if (bar_evt_idx == 3'(b)) evt_kind = BAR_KIND[2*b +: 2];
    end
  end

  assert_bar_evt_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bar_evt |-> ($past(wr_en) && $past(|wr_be) && ($past(wr_dw) >= 6'd4) && ($past(wr_dw) <= 6'd9)));

  assert_rom_evt_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rom_evt |-> ($past(wr_en) && $past(|wr_be) && ($past(wr_dw) == 6'd12)));

  assert_err_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> ($past(wr_en) && $past(|wr_be)));

  assert_io_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_evt && evt_kind == 2'd1) |-> bar_evt_val[0]);

  assert_mem_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_evt && evt_kind == 2'd2) |-> (bar_evt_val[3:0] == 4'h8));

  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_evt && evt_kind == 2'd0) |-> (bar_evt_val == 32'h0));

  assert_cmd_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (HDR_OK && wr_en && wr_dw == 6'd1 && wr_be[0]) |=>
      ((io_en == $past(wr_data[0])) && (mem_en == $past(wr_data[1]))));

  assert_bad_hdr_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !HDR_OK |-> (!bar_evt && !rom_evt));

endmodule

bind cfg_space_bars cfg_space_bars_chk #(
  .BAR_KIND (BAR_KIND),
  .HDR_TYPE (HDR_TYPE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .wr_en       (wr_en),
  .wr_dw       (wr_dw),
  .wr_be       (wr_be),
  .wr_data     (wr_data),
  .io_en       (io_en),
  .mem_en      (mem_en),
  .bar_evt     (bar_evt),
  .bar_evt_idx (bar_evt_idx),
  .bar_evt_val (bar_evt_val),
  .rom_evt     (rom_evt),
  .wr_err      (wr_err)
);

// File: tb/cfg_space_bars_tb.sv
module cfg_space_bars_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_dw = '0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  rd_dw = '0;

  logic [31:0] rd_data, b_rd_data;
  logic        io_en, mem_en, bar_evt, rom_evt, wr_err;
  logic        b_io_en, b_mem_en, b_bar_evt, b_rom_evt, b_wr_err;
  logic [2:0]  bar_evt_idx, b_bar_evt_idx;
  logic [31:0] bar_evt_val, b_bar_evt_val;

  always #2 clk = ~clk;

  cfg_space_bars u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dw(wr_dw), .wr_be(wr_be),
    .wr_data(wr_data), .rd_dw(rd_dw), .rd_data(rd_data), .io_en(io_en),
    .mem_en(mem_en), .bar_evt(bar_evt), .bar_evt_idx(bar_evt_idx),
    .bar_evt_val(bar_evt_val), .rom_evt(rom_evt), .wr_err(wr_err)
  );

  cfg_space_bars #(.HDR_TYPE(8'h02)) u_dut_badhdr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dw(wr_dw), .wr_be(wr_be),
    .wr_data(wr_data), .rd_dw(rd_dw), .rd_data(b_rd_data), .io_en(b_io_en),
    .mem_en(b_mem_en), .bar_evt(b_bar_evt), .bar_evt_idx(b_bar_evt_idx),
    .bar_evt_val(b_bar_evt_val), .rom_evt(b_rom_evt), .wr_err(b_wr_err)
  );

  typedef struct {
    bit        bar;
    bit [2:0]  idx;
    bit [31:0] val;
    bit        rom;
    bit        err;
    bit        berr;
    string     req;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic en, input logic [5:0] dw, input logic [3:0] be,
                    input logic [31:0] data, input bit bar, input bit [2:0] idx,
                    input bit [31:0] val, input bit rom, input bit err, input string req);
    exp_t e;
    @(negedge clk);
    wr_en = en; wr_dw = dw; wr_be = be; wr_data = data;
    @(posedge clk);
    #1;
    e.bar = bar; e.idx = idx; e.val = val; e.rom = rom; e.err = err;
    e.berr = en && (be != 4'h0); e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
    wr_en = 1'b0; wr_be = 4'h0;
  endtask

  task automatic rd(input logic [5:0] dw, input logic [31:0] exp, input string req);
    rd_dw = dw;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic rd_bad(input logic [5:0] dw, input logic [31:0] exp, input string req);
    rd_dw = dw;
    #1;
    chk(req, b_rd_data, exp);
  endtask

  // monitor: pops one expectation per write, otherwise expects silence
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && !done) begin
      if (exp_q.size() > 0) e = exp_q.pop_front();
      else begin
        e.bar = 0; e.idx = 0; e.val = 0; e.rom = 0; e.err = 0; e.berr = 0; e.req = "R13";
      end
      chk({e.req, " bar_evt"}, {31'h0, bar_evt}, {31'h0, e.bar});
      if (e.bar) begin
        chk({e.req, " bar_evt_idx"}, {29'h0, bar_evt_idx}, {29'h0, e.idx});
        chk({e.req, " bar_evt_val"}, bar_evt_val, e.val);
      end
      chk({e.req, " rom_evt"}, {31'h0, rom_evt}, {31'h0, e.rom});
      chk({e.req, " wr_err"}, {31'h0, wr_err}, {31'h0, e.err});
      chk("R12 bad wr_err", {31'h0, b_wr_err}, {31'h0, e.berr});
      chk("R12 bad events", {30'h0, b_bar_evt, b_rom_evt}, 32'h0);
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R13 act=timeout exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset contents, R2 byte placement
    rd(6'd0, 32'h7A31_10EE, "R1 id");
    rd(6'd2, 32'h0C03_0002, "R2 class");
    rd(6'd3, 32'h0000_0000, "R1 hdr");
    rd(6'd4, 32'h0000_C001, "R1 io bar");
    rd(6'd5, 32'hFEB0_0008, "R1 mem bar");
    rd(6'd6, 32'h0, "R1 unused bar");
    rd(6'd1, 32'h0, "R1 cmd");
    chk("R1 io_en", {31'h0, io_en}, 32'h0);
    chk("R1 mem_en", {31'h0, mem_en}, 32'h0);
    rd(6'd0, 32'h7A31_10EE, "R2 repeat read");

    // R5 command, R4 status bytes read-only
    wr(1, 6'd1, 4'hF, 32'hFFFF_0003, 0, 0, 0, 0, 1, "R4");
    rd(6'd1, 32'h0000_0003, "R4 cmd partial");
    chk("R5 io_en", {31'h0, io_en}, 32'h1);
    chk("R5 mem_en", {31'h0, mem_en}, 32'h1);
    wr(1, 6'd1, 4'h1, 32'h0000_0002, 0, 0, 0, 0, 0, "R5");
    chk("R5 io_en off", {31'h0, io_en}, 32'h0);
    chk("R5 mem_en on", {31'h0, mem_en}, 32'h1);

    // R6 BIST, R3 cache/latency, header byte read-only
    wr(1, 6'd3, 4'hF, 32'hAABB_CCDD, 0, 0, 0, 0, 1, "R6");
    rd(6'd3, 32'h0000_CCDD, "R6 bist zero");

    // R7 I/O register sizing and merge
    wr(1, 6'd4, 4'hF, 32'hFFFF_FFFF, 1, 3'd0, 32'hFFFF_FFE1, 0, 0, "R7");
    rd(6'd4, 32'hFFFF_FFE1, "R7 probe");
    wr(1, 6'd4, 4'hF, 32'h0000_D012, 1, 3'd0, 32'h0000_D001, 0, 0, "R7");
    wr(1, 6'd4, 4'h2, 32'h0000_BE00, 1, 3'd0, 32'h0000_BE01, 0, 0, "R10");
    rd(6'd4, 32'h0000_BE01, "R7 lane merge");

    // R8 memory register sizing and merge
    wr(1, 6'd5, 4'hF, 32'hFFFF_FFFF, 1, 3'd1, 32'hFFFF_C008, 0, 0, "R8");
    wr(1, 6'd5, 4'hF, 32'h1234_5677, 1, 3'd1, 32'h1234_4008, 0, 0, "R8");
    wr(1, 6'd5, 4'h8, 32'hAB00_0000, 1, 3'd1, 32'hAB34_4008, 0, 0, "R10");
    rd(6'd5, 32'hAB34_4008, "R8 lane merge");

    // R9 unused registers
    wr(1, 6'd6, 4'hF, 32'hFFFF_FFFF, 1, 3'd2, 32'h0, 0, 0, "R9");
    rd(6'd6, 32'h0, "R9 discard");
    wr(1, 6'd9, 4'h1, 32'h0000_00FF, 1, 3'd5, 32'h0, 0, 0, "R9");
    rd(6'd9, 32'h0, "R9 discard last");

    // R11 expansion ROM
    wr(1, 6'd12, 4'hF, 32'hFFFF_F801, 0, 0, 0, 1, 0, "R11");
    rd(6'd12, 32'hFFFF_F801, "R11 stored");

    // R4 read-only regions
    wr(1, 6'd13, 4'h1, 32'h0000_0055, 0, 0, 0, 0, 1, "R4");
    rd(6'd13, 32'h0, "R4 cap ptr");
    wr(1, 6'd0, 4'hF, 32'h0, 0, 0, 0, 0, 1, "R4");
    rd(6'd0, 32'h7A31_10EE, "R4 id kept");
    wr(1, 6'd10, 4'hF, 32'hFFFF_FFFF, 0, 0, 0, 0, 1, "R4");
    rd(6'd10, 32'h0, "R4 dword 10");

    // R3 interrupt line and device-specific area
    wr(1, 6'd15, 4'hF, 32'h1122_3344, 0, 0, 0, 0, 1, "R3");
    rd(6'd15, 32'h0000_0044, "R3 int line");
    wr(1, 6'd32, 4'h5, 32'hCAFE_F00D, 0, 0, 0, 0, 0, "R3");
    rd(6'd32, 32'h00FE_000D, "R3 dev specific");

    // R13 null writes
    wr(1, 6'd4, 4'h0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R13");
    rd(6'd4, 32'h0000_BE01, "R13 zero be");
    wr(0, 6'd1, 4'hF, 32'h0000_0003, 0, 0, 0, 0, 0, "R13");
    rd(6'd1, 32'h0000_0002, "R13 wr_en low");
    chk("R13 io_en", {31'h0, io_en}, 32'h0);

    // R12 invalid header instance saw every write above
    rd_bad(6'd1, 32'h0, "R12 cmd");
    rd_bad(6'd3, 32'h0002_0000, "R12 hdr");
    rd_bad(6'd4, 32'h0000_C001, "R12 io bar");
    rd_bad(6'd12, 32'h0, "R12 rom");
    rd_bad(6'd32, 32'h0, "R12 dev specific");
    chk("R12 io_en", {30'h0, b_io_en, b_mem_en}, 32'h0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule